// File: doc/BRIEF.md
# Thermal Range Residency Evaluator

This block watches a stream of core temperature samples and sorts each accepted sample into a temperature bin: hot, middle, cool, or the narrow gap between the cool and middle ranges. Over an evaluation window of a programmable number of accepted samples it counts how many samples land in each bin. When the window closes, the counts are frozen and the counters restart at once for the next window.

The frozen counts are then scored against a desired residency for each of the three scored bins. The desired residency is given as a sample count within the same window, so the ratio of actual to desired share equals the ratio of the two counts. One shared sequential divider produces the three scores as unsigned Q8.8 numbers. A score of 1.0 (0x0100) means the core spent exactly the intended time in that range. The three scores are added into one index whose ideal value is 3.0. A designer uses the index to compare thermal-management policies over identical workloads.

Top module: `trr_eval`

## Requirements
- R1: A sample whose temperature (unsigned, whole degrees) is above HOT_ABOVE (default 78) is counted in the hot bin.
- R2: A sample from MID_MIN (default 74) up to and including HOT_ABOVE is counted in the middle bin.
- R3: A sample below COOL_BELOW (default 72) is counted in the cool bin.
- R4: A sample from COOL_BELOW up to MID_MIN-1 (72 and 73 by default) is counted in the gap bin, so every accepted sample falls in exactly one bin.
- R5: A sample is accepted only in a cycle where samp_valid is high. The window closes on the accepted sample that brings the count to win_len (a win_len of 0 acts as 1). That sample is included in the frozen counts, and all bin counters then restart from zero.
- R6: Each score equals floor(count × 256 / desired count) in Q8.8, with bit 8 weighing 1.0. The desired counts are des_hot, des_mid and des_cool, captured when the window closes.
- R7: A score whose quotient exceeds 0xFFFF is reported as 0xFFFF with its error bit clear.
- R8: A desired count of zero gives a score of 0xFFFF and sets that bin's error bit (bit 0 hot, bit 1 middle, bit 2 cool). Otherwise the bit is clear.
- R9: index_sum is the 18-bit sum of the three reported scores.
- R10: res_valid is a single-cycle pulse in the cycle all results (scores, index, error bits, frozen counts) update. The results hold until the next pulse. A window that closes while scoring is in progress produces no results.
- R11: After reset all results are zero and res_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Sample present this cycle |
| samp_temp | input | TW | Temperature in whole degrees, unsigned |
| win_len | input | CW | Accepted samples per window |
| des_hot | input | CW | Desired hot-bin sample count per window |
| des_mid | input | CW | Desired middle-bin sample count per window |
| des_cool | input | CW | Desired cool-bin sample count per window |
| res_valid | output | 1 | One-cycle pulse when new results are posted |
| ratio_hot | output | 16 | Hot score, Q8.8 |
| ratio_mid | output | 16 | Middle score, Q8.8 |
| ratio_cool | output | 16 | Cool score, Q8.8 |
| index_sum | output | 18 | Sum of the three scores, Q10.8 |
| err_zero | output | 3 | Zero-desired flags: bit 0 hot, 1 middle, 2 cool |
| res_cnt_hot | output | CW | Frozen hot-bin count |
| res_cnt_mid | output | CW | Frozen middle-bin count |
| res_cnt_cool | output | CW | Frozen cool-bin count |
| res_cnt_gap | output | CW | Frozen gap-bin count |

## Verification
The bench builds the block with its default parameters: 8-bit temperatures, 10-bit counts, and thresholds at 78, 74 and 72. The 8-bit temperature reaches both extremes of the scale and every threshold edge. The 10-bit count allows a 300-sample window with a desired count of 1, whose quotient of 76800 is the only way to reach the 16-bit saturation of R7. The same width keeps the score and the index wide enough to show a zero-desired bin adding 0xFFFF to the index without overflow.

// File: rtl/trr_pkg.sv
package trr_pkg;
  localparam int RATIO_W = 16;
  localparam int INDEX_W = RATIO_W + 2;
  localparam int FRAC_W  = 8;
  localparam int NBINS   = 4;
  localparam int NSCORED = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_SUM
  } trr_state_e;
endpackage

// File: rtl/trr_classify.sv
module trr_classify #(
  parameter int TW         = 8,
  parameter int HOT_ABOVE  = 78,
  parameter int MID_MIN    = 74,
  parameter int COOL_BELOW = 72
) (
  input  logic [TW-1:0] temp,
  output logic [3:0]    bin_hit
);
  localparam logic [TW-1:0] HOT_T  = TW'(HOT_ABOVE);
  localparam logic [TW-1:0] MID_T  = TW'(MID_MIN);
  localparam logic [TW-1:0] COOL_T = TW'(COOL_BELOW);

  logic is_hot, is_mid, is_cool;

  always_comb begin
    is_hot     = temp > HOT_T;
    is_mid     = (temp >= MID_T) && (temp <= HOT_T);
    is_cool    = temp < COOL_T;
    bin_hit[0] = is_hot;
    bin_hit[1] = is_mid;
    bin_hit[2] = is_cool;
    bin_hit[3] = !(is_hot || is_mid || is_cool);
  end
endmodule

// File: rtl/trr_div.sv
module trr_div #(
  parameter int NW = 18,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW:0]     rem_q, rem_d, shifted;
  logic [NW-1:0]   dq_q, dq_d;
  logic [DW-1:0]   dsr_q, dsr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            busy_q, busy_d, done_q, done_d, fits;

  always_comb begin
    shifted = {rem_q[DW-1:0], dq_q[NW-1]};
    fits    = shifted >= {1'b0, dsr_q};
    rem_d   = rem_q;
    dq_d    = dq_q;
    dsr_d   = dsr_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (start) begin
      rem_d  = '0;
      dq_d   = dividend;
      dsr_d  = divisor;
      cnt_d  = CNTW'(NW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? (shifted - {1'b0, dsr_q}) : shifted;
      dq_d  = {dq_q[NW-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dq_q   <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      dq_q   <= dq_d;
      dsr_q  <= dsr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quot = dq_q;

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R6
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < {1'b0, dsr_q}));
endmodule

// File: rtl/trr_eval.sv
module trr_eval
  import trr_pkg::*;
#(
  parameter int TW         = 8,
  parameter int CW         = 10,
  parameter int HOT_ABOVE  = 78,
  parameter int MID_MIN    = 74,
  parameter int COOL_BELOW = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_valid,
  input  logic [TW-1:0]      samp_temp,
  input  logic [CW-1:0]      win_len,
  input  logic [CW-1:0]      des_hot,
  input  logic [CW-1:0]      des_mid,
  input  logic [CW-1:0]      des_cool,
  output logic               res_valid,
  output logic [RATIO_W-1:0] ratio_hot,
  output logic [RATIO_W-1:0] ratio_mid,
  output logic [RATIO_W-1:0] ratio_cool,
  output logic [INDEX_W-1:0] index_sum,
  output logic [2:0]         err_zero,
  output logic [CW-1:0]      res_cnt_hot,
  output logic [CW-1:0]      res_cnt_mid,
  output logic [CW-1:0]      res_cnt_cool,
  output logic [CW-1:0]      res_cnt_gap
);
  localparam int NW = CW + FRAC_W;
  localparam logic [NW-1:0] QMAX = NW'(17'h0FFFF);

  logic [3:0] bin_hit;
  logic       win_end;

  logic [NBINS-1:0][CW-1:0]   cnt_q, cnt_d, snap_cnt_q, snap_cnt_d, rcnt_q, rcnt_d;
  logic [NSCORED-1:0][CW-1:0] snap_des_q, snap_des_d;
  logic [NSCORED-1:0][RATIO_W-1:0] work_q, work_d, ratio_q, ratio_d;
  logic [CW-1:0]      wcnt_q, wcnt_d;
  logic [2:0]         werr_q, werr_d, err_q, err_d;
  logic [INDEX_W-1:0] idx_q, idx_d;
  logic               rv_q, rv_d;
  trr_state_e         state_q, state_d;
  logic [1:0]         bidx_q, bidx_d;

  logic               div_start, div_busy, div_done;
  logic [NW-1:0]      div_quot;
  logic [RATIO_W-1:0] div_sat;

  trr_classify #(
    .TW(TW), .HOT_ABOVE(HOT_ABOVE), .MID_MIN(MID_MIN), .COOL_BELOW(COOL_BELOW)
  ) u_class (
    .temp    (samp_temp),
    .bin_hit (bin_hit)
  );

  trr_div #(.NW(NW), .DW(CW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend ({snap_cnt_q[bidx_q], {FRAC_W{1'b0}}}),
    .divisor  (snap_des_q[bidx_q]),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_quot)
  );

  assign win_end = samp_valid && (({1'b0, wcnt_q} + 1'b1) >= {1'b0, win_len});
  assign div_sat = (div_quot > QMAX) ? {RATIO_W{1'b1}} : div_quot[RATIO_W-1:0];

  // window and bin counters
  always_comb begin
    cnt_d  = cnt_q;
    wcnt_d = wcnt_q;
    if (win_end) begin
      cnt_d  = '0;
      wcnt_d = '0;
    end else if (samp_valid) begin
      wcnt_d = wcnt_q + 1'b1;
      for (int i = 0; i < NBINS; i++)
        if (bin_hit[i]) cnt_d[i] = cnt_q[i] + 1'b1;
    end
  end

  // scoring sequencer
  always_comb begin
    state_d    = state_q;
    bidx_d     = bidx_q;
    snap_cnt_d = snap_cnt_q;
    snap_des_d = snap_des_q;
    work_d     = work_q;
    werr_d     = werr_q;
    ratio_d    = ratio_q;
    err_d      = err_q;
    idx_d      = idx_q;
    rcnt_d     = rcnt_q;
    rv_d       = 1'b0;
    div_start  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (win_end) begin
          for (int i = 0; i < NBINS; i++)
            snap_cnt_d[i] = cnt_q[i] + {{(CW-1){1'b0}}, bin_hit[i]};
          snap_des_d = {des_cool, des_mid, des_hot};
          bidx_d     = 2'd0;
          state_d    = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (snap_des_q[bidx_q] == '0) begin
          work_d[bidx_q] = {RATIO_W{1'b1}};
          werr_d[bidx_q] = 1'b1;
          if (bidx_q == 2'd2) state_d = ST_SUM;
          else bidx_d = bidx_q + 1'b1;
        end else begin
          div_start = 1'b1;
          state_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (div_done) begin
          work_d[bidx_q] = div_sat;
          werr_d[bidx_q] = 1'b0;
          if (bidx_q == 2'd2) begin
            state_d = ST_SUM;
          end else begin
            bidx_d  = bidx_q + 1'b1;
            state_d = ST_LOAD;
          end
        end
      end
      default: begin
        ratio_d = work_q;
        err_d   = werr_q;
        idx_d   = INDEX_W'(work_q[0]) + INDEX_W'(work_q[1]) + INDEX_W'(work_q[2]);
        rcnt_d  = snap_cnt_q;
        rv_d    = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      wcnt_q     <= '0;
      state_q    <= ST_IDLE;
      bidx_q     <= '0;
      snap_cnt_q <= '0;
      snap_des_q <= '0;
      work_q     <= '0;
      werr_q     <= '0;
      ratio_q    <= '0;
      err_q      <= '0;
      idx_q      <= '0;
      rcnt_q     <= '0;
      rv_q       <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      wcnt_q     <= wcnt_d;
      state_q    <= state_d;
      bidx_q     <= bidx_d;
      snap_cnt_q <= snap_cnt_d;
      snap_des_q <= snap_des_d;
      work_q     <= work_d;
      werr_q     <= werr_d;
      ratio_q    <= ratio_d;
      err_q      <= err_d;
      idx_q      <= idx_d;
      rcnt_q     <= rcnt_d;
      rv_q       <= rv_d;
    end
  end

  assign res_valid    = rv_q;
  assign ratio_hot    = ratio_q[0];
  assign ratio_mid    = ratio_q[1];
  assign ratio_cool   = ratio_q[2];
  assign index_sum    = idx_q;
  assign err_zero     = err_q;
  assign res_cnt_hot  = rcnt_q[0];
  assign res_cnt_mid  = rcnt_q[1];
  assign res_cnt_cool = rcnt_q[2];
  assign res_cnt_gap  = rcnt_q[3];

  // R4
  one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |-> $onehot(bin_hit));

  // R5
  bins_match_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((CW+2)'(cnt_q[0]) + (CW+2)'(cnt_q[1]) + (CW+2)'(cnt_q[2]) + (CW+2)'(cnt_q[3]))
      == (CW+2)'(wcnt_q));

  // R10
  rv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(index_sum) && $stable(err_zero)));

  // R8
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((!err_zero[0] || ratio_hot  == 16'hFFFF) &&
                   (!err_zero[1] || ratio_mid  == 16'hFFFF) &&
                   (!err_zero[2] || ratio_cool == 16'hFFFF)));
endmodule

// File: tb/trr_eval_tb.sv
module trr_eval_tb;
  localparam int TW = 8;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          samp_valid = 1'b0;
  logic [TW-1:0] samp_temp = '0;
  logic [CW-1:0] win_len = '0;
  logic [CW-1:0] des_hot = '0, des_mid = '0, des_cool = '0;
  logic          res_valid;
  logic [15:0]   ratio_hot, ratio_mid, ratio_cool;
  logic [17:0]   index_sum;
  logic [2:0]    err_zero;
  logic [CW-1:0] res_cnt_hot, res_cnt_mid, res_cnt_cool, res_cnt_gap;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  trr_eval #(.TW(TW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp(samp_temp),
    .win_len(win_len), .des_hot(des_hot), .des_mid(des_mid), .des_cool(des_cool),
    .res_valid(res_valid), .ratio_hot(ratio_hot), .ratio_mid(ratio_mid),
    .ratio_cool(ratio_cool), .index_sum(index_sum), .err_zero(err_zero),
    .res_cnt_hot(res_cnt_hot), .res_cnt_mid(res_cnt_mid),
    .res_cnt_cool(res_cnt_cool), .res_cnt_gap(res_cnt_gap)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int t);
    @(negedge clk);
    samp_valid = 1'b1;
    samp_temp  = TW'(t);
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_result(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (res_valid) seen = 1'b1;
    end
    check({tag, " res_valid pulse"}, seen, 1);
  endtask

  task automatic check_scores(input string tag, input int rh, input int rm, input int rc,
                              input int ix, input int er);
    check({tag, " R6 R7 ratio_hot"}, ratio_hot, rh);
    check({tag, " R6 R8 ratio_mid"}, ratio_mid, rm);
    check({tag, " R6 ratio_cool"}, ratio_cool, rc);
    check({tag, " R9 index_sum"}, index_sum, ix);
    check({tag, " R8 err_zero"}, err_zero, er);
  endtask

  task automatic check_counts(input string tag, input int h, input int m, input int c, input int g);
    check({tag, " R1 hot count"}, res_cnt_hot, h);
    check({tag, " R2 mid count"}, res_cnt_mid, m);
    check({tag, " R3 cool count"}, res_cnt_cool, c);
    check({tag, " R4 gap count"}, res_cnt_gap, g);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R11 res_valid", res_valid, 0);
    check("R11 index_sum", index_sum, 0);
    check("R11 ratio_hot", ratio_hot, 0);
    check("R11 err_zero", err_zero, 0);
    check("R11 res_cnt_gap", res_cnt_gap, 0);
  endtask

  // bin edges, idle cycles between samples ignored (R5)
  task automatic t_edges();
    win_len = 10; des_hot = 5; des_mid = 3; des_cool = 2;
    send(79); idle(3); send(90); send(255); send(74); idle(2); send(76);
    send(78); send(0); send(71); send(72); idle(4);
    check("R5 no result before window closes", res_valid, 0);
    send(73);
    wait_result("edges");
    check_counts("edges", 3, 3, 2, 2);
    // 3*256/5=153, 3*256/3=256, 2*256/2=256
    check_scores("edges", 153, 256, 256, 665, 0);
    @(negedge clk);
    check("R10 pulse width", res_valid, 0);
    check("R10 hold index", index_sum, 665);
  endtask

  // zero desired count, counters restarted after previous window (R5)
  task automatic t_zero_desired();
    win_len = 4; des_hot = 2; des_mid = 0; des_cool = 4;
    send(80); send(75); send(75); send(10);
    wait_result("zero");
    check_counts("zero R5", 1, 2, 1, 0);
    check_scores("zero", 128, 65535, 64, 128 + 65535 + 64, 3'b010);
  endtask

  // score above one, bins with no residency
  task automatic t_above_one();
    win_len = 8; des_hot = 2; des_mid = 1; des_cool = 4;
    for (int i = 0; i < 8; i++) send(50);
    wait_result("above");
    check_counts("above", 0, 0, 8, 0);
    check_scores("above", 0, 0, 512, 512, 0);
  endtask

  // 16-bit saturation without error flag (R7)
  task automatic t_saturate();
    win_len = 300; des_hot = 1; des_mid = 4; des_cool = 7;
    for (int i = 0; i < 300; i++) send(100);
    wait_result("sat");
    check("sat R5 hot count", res_cnt_hot, 300);
    check_scores("sat R7", 65535, 0, 0, 65535, 0);
  endtask

  // win_len of zero acts as one (R5)
  task automatic t_len_zero();
    win_len = 0; des_hot = 1; des_mid = 1; des_cool = 1;
    send(73);
    wait_result("len0");
    check_counts("len0 R5", 0, 0, 0, 1);
    check_scores("len0", 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_edges();
    t_zero_desired();
    t_above_one();
    t_saturate();
    t_len_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule